// File: doc/BRIEF.md
# Address-Wake Asynchronous Serial Receiver

This block receives asynchronous serial frames that carry one extra bit after the data byte. When that bit is 1 the frame is an address (ID) frame; when it is 0 the frame holds ordinary data. Several receivers can share one line this way. Each receiver ignores traffic until it is addressed, and its processor is only interrupted from that point on.

Software sets a wake filter bit. While the filter is armed and multiprocessor operation is enabled, the receiver still shifts every frame in, but it drops all data frames. No data register load, no status flag and no interrupt results from them. The first frame whose extra bit is 1 is received normally and clears the filter bit in hardware, so every frame after it is also received normally. Bit timing is taken from a one-cycle oversample tick that runs at 16 times the bit rate. No baud generator is part of the block.

Top module: `mpwake_uart_rx`

## Requirements
- R1: After reset, rx_data is 0, and rx_full, frm_err, ovr_err, mpb_flag, wake_en, rx_irq and err_irq are all 0.
- R2: A frame is a low start bit, 8 data bits with the least significant bit first, the multiprocessor bit, and a stop bit. A start is detected on the first os_tick at which rxd is low. It is confirmed 8 ticks later. If rxd is high at that point the start is dropped and nothing is received. Each later bit is sampled 16 ticks after the one before it.
- R3: A frame that is accepted while rx_full is 0 loads its byte into rx_data, sets rx_full, and copies its multiprocessor bit into mpb_flag. rx_full never rises without a completed frame.
- R4: A frame that is accepted while rx_full is 1 (and rdr_take is not high in that cycle) sets ovr_err. rx_data and mpb_flag keep their old values.
- R5: An accepted frame whose stop bit samples as 0 sets frm_err. This also applies when the frame causes an overrun.
- R6: The filter is active when cfg_mp_en is 1 and wake_en is 1. While it is active, a frame whose multiprocessor bit is 0 leaves rx_data, rx_full, mpb_flag, frm_err and ovr_err unchanged, even if its stop bit is 0 or rx_full is already set.
- R7: While the filter is active, rx_irq and err_irq are 0, whatever the flags and enables are.
- R8: While the filter is active, a frame whose multiprocessor bit is 1 is accepted as described in R3, R4 and R5, and wake_en is cleared to 0. Frames after it are accepted normally.
- R9: With cfg_mp_en at 0, wake_en has no effect. Every frame is accepted, and a frame whose multiprocessor bit is 1 does not clear wake_en.
- R10: A cycle with wake_wr high loads wake_wdata into wake_en. When the hardware clear of R8 falls in the same cycle, wake_en becomes 0.
- R11: When the filter is inactive, rx_irq equals cfg_rx_ie AND rx_full, and err_irq equals cfg_err_ie AND (frm_err OR ovr_err).
- R12: rdr_take clears rx_full and err_clr clears frm_err and ovr_err. A frame accepted in the same cycle as rdr_take loads normally, with no overrun. A frame that sets an error flag in the same cycle as err_clr leaves that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| cfg_mp_en | input | 1 | Multiprocessor mode enable |
| cfg_rx_ie | input | 1 | Receive interrupt enable |
| cfg_err_ie | input | 1 | Error interrupt enable |
| wake_wr | input | 1 | Write strobe for the wake filter bit |
| wake_wdata | input | 1 | Value written to the wake filter bit |
| rdr_take | input | 1 | Pulse: the data register has been read, clear rx_full |
| err_clr | input | 1 | Pulse: clear frm_err and ovr_err |
| rx_data | output | 8 | Received data register |
| rx_full | output | 1 | Receive data register full |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun error flag |
| mpb_flag | output | 1 | Multiprocessor bit of the last loaded frame |
| wake_en | output | 1 | Wake filter bit |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The os_tick edge that samples the stop bit registers a frame-done strobe. The next clock edge updates rx_data, rx_full, mpb_flag, frm_err, ovr_err and the hardware clear of wake_en, so these results are due two edges after that tick. Software pulses take effect on the first edge that samples them, and both interrupt outputs follow the flags and enables with no delay. The bench model steps on the same edges, with a one-edge pending slot between the stop-bit sample and the flag update, and it is compared shortly after each falling edge. The same-cycle priority cases are hit by raising the software pulse at the falling edge that lies between those two edges.

// File: rtl/mpw_pkg.sv
package mpw_pkg;
    localparam int unsigned MPW_DATA_W = 8;
    localparam int unsigned MPW_OVS    = 16;

    typedef enum logic [1:0] {
        SMP_IDLE  = 2'd0,
        SMP_START = 2'd1,
        SMP_BITS  = 2'd2
    } smp_state_e;
endpackage

// File: rtl/mpw_bit_sampler.sv
module mpw_bit_sampler
    import mpw_pkg::*;
#(
    parameter int unsigned DATA_W = MPW_DATA_W,
    parameter int unsigned OVS    = MPW_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    output logic              frm_done,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_mp,
    output logic              frm_stop
);
    localparam int unsigned NBITS = DATA_W + 2;
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned IDX_W = $clog2(NBITS);
    localparam int unsigned MID   = OVS / 2 - 1;

    typedef struct packed {
        smp_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [NBITS-1:0] shf;
        logic             done;
    } smp_t;

    smp_t smp_q, smp_d;

    always_comb begin
        smp_d      = smp_q;
        smp_d.done = 1'b0;
        if (os_tick) begin
            case (smp_q.st)
                SMP_IDLE: begin
                    if (!rxd) begin
                        smp_d.st  = SMP_START;
                        smp_d.cnt = '0;
                    end
                end
                SMP_START: begin
                    if (smp_q.cnt == CNT_W'(MID)) begin
                        smp_d.cnt = '0;
                        smp_d.idx = '0;
                        smp_d.st  = rxd ? SMP_IDLE : SMP_BITS;
                    end else begin
                        smp_d.cnt = smp_q.cnt + CNT_W'(1);
                    end
                end
                SMP_BITS: begin
                    if (smp_q.cnt == CNT_W'(OVS - 1)) begin
                        smp_d.cnt = '0;
                        smp_d.shf = {rxd, smp_q.shf[NBITS-1:1]};
                        if (smp_q.idx == IDX_W'(NBITS - 1)) begin
                            smp_d.done = 1'b1;
                            smp_d.st   = SMP_IDLE;
                        end else begin
                            smp_d.idx = smp_q.idx + IDX_W'(1);
                        end
                    end else begin
                        smp_d.cnt = smp_q.cnt + CNT_W'(1);
                    end
                end
                default: smp_d.st = SMP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign frm_done = smp_q.done;
    assign frm_data = smp_q.shf[DATA_W-1:0];
    assign frm_mp   = smp_q.shf[DATA_W];
    assign frm_stop = smp_q.shf[NBITS-1];
endmodule

// File: rtl/mpw_wake_filter.sv
module mpw_wake_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic mp_en,
    input  logic frm_done,
    input  logic frm_mp,
    input  logic wake_wr,
    input  logic wake_wdata,
    output logic wake_en,
    output logic filt_on,
    output logic accept
);
    typedef struct packed {
        logic wake;
    } wk_t;

    wk_t  wk_q, wk_d;
    logic hw_clr;

    always_comb begin
        filt_on = mp_en & wk_q.wake;
        accept  = frm_done & (~filt_on | frm_mp);
        hw_clr  = frm_done & filt_on & frm_mp;
        wk_d    = wk_q;
        if (hw_clr)       wk_d.wake = 1'b0;
        else if (wake_wr) wk_d.wake = wake_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign wake_en = wk_q.wake;
endmodule

// File: rtl/mpw_rx_status.sv
module mpw_rx_status
    import mpw_pkg::*;
#(
    parameter int unsigned DATA_W = MPW_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              filt_on,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_mp,
    input  logic              frm_stop,
    input  logic              rdr_take,
    input  logic              err_clr,
    input  logic              rx_ie,
    input  logic              err_ie,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              mpb_flag,
    output logic              rx_irq,
    output logic              err_irq
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
        logic              fe;
        logic              oe;
        logic              mpb;
    } st_t;

    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (rdr_take) st_d.full = 1'b0;
        if (err_clr) begin
            st_d.fe = 1'b0;
            st_d.oe = 1'b0;
        end
        if (accept) begin
            if (st_q.full && !rdr_take) begin
                st_d.oe = 1'b1;
            end else begin
                st_d.data = frm_data;
                st_d.full = 1'b1;
                st_d.mpb  = frm_mp;
            end
            if (!frm_stop) st_d.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_data  = st_q.data;
    assign rx_full  = st_q.full;
    assign frm_err  = st_q.fe;
    assign ovr_err  = st_q.oe;
    assign mpb_flag = st_q.mpb;
    assign rx_irq   = rx_ie & st_q.full & ~filt_on;
    assign err_irq  = err_ie & (st_q.fe | st_q.oe) & ~filt_on;
endmodule

// File: rtl/mpwake_uart_rx.sv
module mpwake_uart_rx
    import mpw_pkg::*;
#(
    parameter int unsigned DATA_W = MPW_DATA_W,
    parameter int unsigned OVS    = MPW_OVS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              cfg_mp_en,
    input  logic              cfg_rx_ie,
    input  logic              cfg_err_ie,
    input  logic              wake_wr,
    input  logic              wake_wdata,
    input  logic              rdr_take,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              mpb_flag,
    output logic              wake_en,
    output logic              rx_irq,
    output logic              err_irq
);
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_mp;
    logic              frm_stop;
    logic              filt_on;
    logic              accept;

    mpw_bit_sampler #(.DATA_W(DATA_W), .OVS(OVS)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .frm_done (frm_done),
        .frm_data (frm_data),
        .frm_mp   (frm_mp),
        .frm_stop (frm_stop)
    );

    mpw_wake_filter u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .mp_en      (cfg_mp_en),
        .frm_done   (frm_done),
        .frm_mp     (frm_mp),
        .wake_wr    (wake_wr),
        .wake_wdata (wake_wdata),
        .wake_en    (wake_en),
        .filt_on    (filt_on),
        .accept     (accept)
    );

    mpw_rx_status #(.DATA_W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .filt_on  (filt_on),
        .frm_data (frm_data),
        .frm_mp   (frm_mp),
        .frm_stop (frm_stop),
        .rdr_take (rdr_take),
        .err_clr  (err_clr),
        .rx_ie    (cfg_rx_ie),
        .err_ie   (cfg_err_ie),
        .rx_data  (rx_data),
        .rx_full  (rx_full),
        .frm_err  (frm_err),
        .ovr_err  (ovr_err),
        .mpb_flag (mpb_flag),
        .rx_irq   (rx_irq),
        .err_irq  (err_irq)
    );
endmodule

// File: rtl/mpw_rx_chk.sv
module mpw_rx_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mp_en,
    input logic              wake_wr,
    input logic              wake_wdata,
    input logic              rdr_take,
    input logic              err_clr,
    input logic              frm_done,
    input logic [DATA_W-1:0] frm_data,
    input logic              frm_mp,
    input logic              frm_stop,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              frm_err,
    input logic              ovr_err,
    input logic              mpb_flag,
    input logic              wake_en,
    input logic              rx_irq,
    input logic              err_irq
);
    logic filt, acc;
    assign filt = cfg_mp_en && wake_en;
    assign acc  = frm_done && (!filt || frm_mp);

    AST_LOAD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (!rx_full || rdr_take)) |=> (rx_full && rx_data == $past(frm_data) && mpb_flag == $past(frm_mp))); // R3
    AST_FULL_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> !$rose(rx_full)); // R3
    AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rx_full && !rdr_take) |=> (ovr_err && $stable(rx_data) && $stable(mpb_flag))); // R4
    AST_STOP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !frm_stop) |=> frm_err); // R5
    AST_FILTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && filt && !frm_mp) |=> ($stable(rx_data) && $stable(mpb_flag) && !$rose(rx_full) && !$rose(frm_err) && !$rose(ovr_err))); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        filt |-> (!rx_irq && !err_irq)); // R7
    AST_WAKE_HW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && filt && frm_mp) |=> !wake_en); // R8
    AST_WAKE_KEEP_NOMP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_mp_en && !wake_wr) |=> $stable(wake_en)); // R9
    AST_WAKE_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_wr && !(frm_done && filt && frm_mp)) |=> (wake_en == $past(wake_wdata))); // R10
    AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !frm_done) |=> (!frm_err && !ovr_err)); // R12
endmodule

bind mpwake_uart_rx mpw_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mp_en  (cfg_mp_en),
    .wake_wr    (wake_wr),
    .wake_wdata (wake_wdata),
    .rdr_take   (rdr_take),
    .err_clr    (err_clr),
    .frm_done   (frm_done),
    .frm_data   (frm_data),
    .frm_mp     (frm_mp),
    .frm_stop   (frm_stop),
    .rx_data    (rx_data),
    .rx_full    (rx_full),
    .frm_err    (frm_err),
    .ovr_err    (ovr_err),
    .mpb_flag   (mpb_flag),
    .wake_en    (wake_en),
    .rx_irq     (rx_irq),
    .err_irq    (err_irq)
);

// File: tb/mpwake_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mpwake_uart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_mp_en = 1'b0, cfg_rx_ie = 1'b1, cfg_err_ie = 1'b1;
    logic       wake_wr = 1'b0, wake_wdata = 1'b0, rdr_take = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, frm_err, ovr_err, mpb_flag, wake_en, rx_irq, err_irq;

    int d_total = 0, d_bad = 0, m_total = 0, m_bad = 0;
    bit fin = 0;

    always #2.5 clk = ~clk;

    mpwake_uart_rx dut_i (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_mp_en(cfg_mp_en), .cfg_rx_ie(cfg_rx_ie), .cfg_err_ie(cfg_err_ie),
        .wake_wr(wake_wr), .wake_wdata(wake_wdata), .rdr_take(rdr_take), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .frm_err(frm_err), .ovr_err(ovr_err),
        .mpb_flag(mpb_flag), .wake_en(wake_en), .rx_irq(rx_irq), .err_irq(err_irq)
    );

    // tick generator: one pulse every 4 clocks
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div = (div + 1) % 4;
            os_tick = rst_n && (div == 0);
        end
    end

    // behavioural reference model
    logic [7:0] m_data = '0;
    logic       m_full = 0, m_fe = 0, m_oe = 0, m_mpb = 0, m_wake = 0;
    logic       m_pend = 0, p_mp = 0, p_stop = 0;
    logic [7:0] p_data = '0;
    logic [9:0] m_bits = '0;
    bit         m_busy = 0;
    int         m_tn = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_data = '0; m_full = 0; m_fe = 0; m_oe = 0; m_mpb = 0; m_wake = 0;
            m_pend = 0; m_busy = 0; m_tn = 0;
        end else begin
            bit filt, hwclr;
            filt  = cfg_mp_en && m_wake;
            hwclr = 0;
            if (rdr_take) m_full = 0;
            if (err_clr) begin m_fe = 0; m_oe = 0; end
            if (m_pend && (!filt || p_mp)) begin
                if (m_full) m_oe = 1;
                else begin m_data = p_data; m_full = 1; m_mpb = p_mp; end
                if (!p_stop) m_fe = 1;
                if (filt) hwclr = 1;
            end
            if (hwclr) m_wake = 0;
            else if (wake_wr) m_wake = wake_wdata;
            m_pend = 0;
            if (os_tick) begin
                if (!m_busy) begin
                    if (!rxd) begin m_busy = 1; m_tn = 0; end
                end else begin
                    m_tn++;
                    if (m_tn == 8) begin
                        if (rxd) m_busy = 0;
                    end else if (m_tn > 8 && (m_tn - 8) % 16 == 0) begin
                        int k;
                        k = (m_tn - 8) / 16;
                        m_bits[k-1] = rxd;
                        if (k == 10) begin
                            m_pend = 1; p_data = m_bits[7:0]; p_mp = m_bits[8];
                            p_stop = m_bits[9]; m_busy = 0;
                        end
                    end
                end
            end
        end
    end

    task automatic mchk(input string tag, input int act, input int exp);
        m_total++;
        if (act != exp) begin
            m_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !fin) begin
            bit mf;
            mf = cfg_mp_en && m_wake;
            mchk("R3 rx_data", rx_data, m_data);
            mchk("R3 rx_full", rx_full, m_full);
            mchk("R3 mpb_flag", mpb_flag, m_mpb);
            mchk("R4 ovr_err", ovr_err, m_oe);
            mchk("R5 frm_err", frm_err, m_fe);
            mchk("R10 wake_en", wake_en, m_wake);
            mchk("R11 rx_irq", rx_irq, cfg_rx_ie && m_full && !mf);
            mchk("R11 err_irq", err_irq, cfg_err_ie && (m_fe || m_oe) && !mf);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        d_total++;
        if (act != exp) begin
            d_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic mp, input logic stp);
        logic [10:0] bits;
        bits = {stp, mp, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = bits[i];
            repeat (64) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (32) @(negedge clk);
    endtask

    task automatic pulse_take();
        @(negedge clk); rdr_take = 1; @(negedge clk); rdr_take = 0;
    endtask

    task automatic pulse_eclr();
        @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    endtask

    task automatic wake_write(input logic v);
        @(negedge clk); wake_wr = 1; wake_wdata = v; @(negedge clk); wake_wr = 0;
    endtask

    task automatic finish_run();
        fin = 1;
        $display("test done: total=%0d bad=%0d", d_total + m_total, d_bad + m_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        d_total++; d_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        chk("R1 flags", {rx_full, frm_err, ovr_err, mpb_flag, wake_en}, 0);
        chk("R1 irqs", {rx_irq, err_irq}, 0);

        // R2 / R3 plain reception, mp mode off
        send_frame(8'hA5, 0, 1);
        chk("R2 data A5", rx_data, 8'hA5);
        chk("R3 full", rx_full, 1);
        chk("R3 mpb 0", mpb_flag, 0);
        chk("R11 rx_irq", rx_irq, 1);
        pulse_take();
        chk("R12 take clears full", rx_full, 0);
        send_frame(8'h3C, 1, 1);
        chk("R2 data 3C", rx_data, 8'h3C);
        chk("R3 mpb 1", mpb_flag, 1);
        pulse_take();

        // R4 overrun
        send_frame(8'h11, 0, 1);
        send_frame(8'h22, 0, 1);
        chk("R4 ovr set", ovr_err, 1);
        chk("R4 data kept", rx_data, 8'h11);
        chk("R4 mpb kept", mpb_flag, 0);
        chk("R11 err_irq", err_irq, 1);
        cfg_err_ie = 0;
        @(negedge clk);
        chk("R11 err_irq disabled", err_irq, 0);
        cfg_err_ie = 1;
        pulse_eclr();
        chk("R12 eclr", ovr_err, 0);
        pulse_take();

        // R5 framing error
        send_frame(8'h5A, 0, 0);
        chk("R5 fe", frm_err, 1);
        chk("R5 data", rx_data, 8'h5A);
        pulse_eclr();
        pulse_take();

        // R9 wake ignored when mp mode off
        wake_write(1);
        send_frame(8'h77, 1, 1);
        chk("R9 accepted", rx_data, 8'h77);
        chk("R9 wake kept", wake_en, 1);
        pulse_take();
        wake_write(0);

        // R6 / R7 / R8 filter
        cfg_mp_en = 1;
        send_frame(8'h66, 0, 1);
        chk("R8 normal with wake 0", rx_data, 8'h66);
        wake_write(1);
        chk("R7 rx_irq masked", rx_irq, 0);
        send_frame(8'h44, 0, 0);
        chk("R6 data held", rx_data, 8'h66);
        chk("R6 no fe", frm_err, 0);
        chk("R6 no ovr", ovr_err, 0);
        chk("R6 full held", rx_full, 1);
        chk("R7 err_irq masked", err_irq, 0);
        pulse_take();
        send_frame(8'h9B, 0, 1);
        chk("R6 dropped full", rx_full, 0);
        send_frame(8'h99, 1, 1);
        chk("R8 id data", rx_data, 8'h99);
        chk("R8 mpb", mpb_flag, 1);
        chk("R8 wake cleared", wake_en, 0);
        chk("R8 rx_irq", rx_irq, 1);
        pulse_take();
        send_frame(8'h12, 0, 1);
        chk("R8 after id", rx_data, 8'h12);
        chk("R8 after id full", rx_full, 1);
        pulse_take();

        // R2 false start
        rxd = 0;
        repeat (12) @(negedge clk);
        rxd = 1;
        repeat (800) @(negedge clk);
        chk("R2 glitch no frame", rx_full, 0);
        chk("R2 glitch data", rx_data, 8'h12);

        // R10 hw clear beats sw write
        wake_write(1);
        fork
            send_frame(8'h3E, 1, 1);
            begin
                do @(negedge clk); while (!m_pend);
                wake_wr = 1; wake_wdata = 1;
                @(negedge clk);
                wake_wr = 0;
            end
        join
        chk("R10 hw clear wins", wake_en, 0);
        chk("R10 id data", rx_data, 8'h3E);

        // R12 same-cycle take and error clear
        fork
            send_frame(8'hC3, 0, 0);
            begin
                do @(negedge clk); while (!m_pend);
                rdr_take = 1; err_clr = 1;
                @(negedge clk);
                rdr_take = 0; err_clr = 0;
            end
        join
        chk("R12 loaded", rx_data, 8'hC3);
        chk("R12 full", rx_full, 1);
        chk("R12 no ovr", ovr_err, 0);
        chk("R12 fe wins", frm_err, 1);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule